// File: doc/BRIEF.md
# AXI4 Write Burst Master with Deferred Address Issue

This block sits between a compute kernel and an AXI4 memory port and handles the write direction only. The kernel hands over one job at a time: a start byte address and a length in data words. It then streams the words in order. The block splits the job into AXI4 write bursts, drives the address (AW) and data (W) channels, and collects one write response (B) per burst. Once every burst of the job has been answered, it gives the kernel a single one-cycle acknowledgement that carries a merged error flag.

Bursts are cut at the maximum burst length and at every 4 KB address page. Incoming words go through a data FIFO. In hold mode an address is not presented until all words of that burst, and of every burst already issued ahead of it, are sitting in the FIFO. This keeps the interconnect from waiting on a slow producer. With the mode input low, addresses go out as soon as fragmentation allows. In both modes the number of bursts still waiting for a response is capped.

The control FSM has four states. `ST_IDLE` accepts a job and moves to `ST_ISSUE`. `ST_ISSUE` stays in place for each address handshake until the last fragment of the job, then moves to `ST_WAIT`. `ST_WAIT` moves to `ST_ACK` once no burst awaits a response. `ST_ACK` pulses the acknowledgement and returns to `ST_IDLE`.

Top module: `axi_wr_burst_master`

## Requirements
- R1: After reset, `awvalid`, `wvalid` and `ack_valid` are low and `req_ready` is high.
- R2: Each burst carries min(remaining words, MAX_BURST, words left before the next 4 KB page) beats, and `awlen` is that count minus one. Bursts follow each other in ascending address order, advancing DATA_W/8 bytes per word, and together cover the job. Job lengths are 1 or more and addresses are word aligned.
- R3: No burst crosses a 4 KB address page.
- R4: W data words leave in exactly the order the kernel supplied them, and each word is held stable while stalled.
- R5: `wlast` is high on the final beat of each burst and low on every other beat.
- R6: With `hold_aw`=1, an address handshake for a burst occurs only after the kernel has delivered every word of that burst and of all earlier bursts of the job.
- R7: With `hold_aw`=0, the first address of a job is issued even when the kernel has not yet delivered any data.
- R8: No address is issued while MAX_OUT bursts are awaiting B responses.
- R9: `ack_valid` is a single-cycle pulse, given exactly once per job, and only after the B responses for all of that job's bursts have arrived.
- R10: `ack_err` is 1 with the acknowledgement if and only if any burst of the job returned a response code other than OKAY (2'b00).
- R11: When the data FIFO holds FIFO_DEPTH words, `wd_ready` is low and no further word is accepted.
- R12: `req_ready` is low from job acceptance until the acknowledgement, and high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_aw | input | 1 | 1: defer each address until its data is buffered; 0: issue at once |
| req_valid | input | 1 | Job offered |
| req_ready | output | 1 | Job accepted when both high |
| req_addr | input | ADDR_W | Job start byte address (word aligned) |
| req_len | input | LEN_W | Job length in words (at least 1) |
| wd_valid | input | 1 | Kernel data word valid |
| wd_ready | output | 1 | Data FIFO can accept a word |
| wd_data | input | DATA_W | Kernel data word |
| ack_valid | output | 1 | One-cycle job completion pulse |
| ack_err | output | 1 | Some burst of the job reported an error |
| awvalid | output | 1 | AXI4 write address valid |
| awready | input | 1 | AXI4 write address ready |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Burst beats minus one |
| wvalid | output | 1 | AXI4 write data valid |
| wready | input | 1 | AXI4 write data ready |
| wdata | output | DATA_W | Write data |
| wlast | output | 1 | Final beat of the burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Always high |
| bresp | input | 2 | Write response code |

## Verification
The bench builds the block with 32-bit data, MAX_BURST=4, MAX_OUT=2 and FIFO_DEPTH=8. Short bursts mean that jobs of a few dozen words split into many fragments and reach the length limit, while the 4 KB page is reached by starting near its end. An outstanding limit of two is hit as soon as responses are withheld. An eight-word FIFO fills within a few cycles when the address channel is stalled. Together these settings let the directed cases exercise hold mode, immediate mode, the cap and backpressure in a few hundred cycles.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_ACK
    } wbm_state_e;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam int         PAGE_BYTES = 4096;
endpackage

// File: rtl/wbm_fifo.sv
module wbm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_wr, do_rd;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wbm_frag.sv
module wbm_frag #(
    parameter int LEN_W     = 12,
    parameter int MAX_BURST = 16,
    parameter int BYTES     = 4,
    localparam int BL_W  = $clog2(MAX_BURST + 1),
    localparam int OFF_W = (BYTES > 1) ? $clog2(BYTES) : 0
) (
    input  logic [11:0]      page_off,
    input  logic [LEN_W-1:0] remaining,
    output logic [BL_W-1:0]  beats
);
    logic [31:0] room_words;
    logic [31:0] rem_words;
    logic [31:0] pick;

    generate
        if (OFF_W == 0) begin : g_byte_words
            assign room_words = 32'(wbm_pkg::PAGE_BYTES) - 32'(page_off);
        end else begin : g_wide_words
            assign room_words = (32'(wbm_pkg::PAGE_BYTES) - 32'(page_off)) >> OFF_W;
        end
    endgenerate

    assign rem_words = 32'(remaining);

    always_comb begin
        pick = 32'(MAX_BURST);
        if (rem_words < pick)  pick = rem_words;
        if (room_words < pick) pick = room_words;
        beats = BL_W'(pick);
    end
endmodule

// File: rtl/wbm_wlane.sv
module wbm_wlane #(
    parameter int DATA_W     = 32,
    parameter int MAX_BURST  = 16,
    parameter int MAX_OUT    = 16,
    parameter int FIFO_DEPTH = 32,
    localparam int BL_W  = $clog2(MAX_BURST + 1),
    localparam int FCNT_W = $clog2(FIFO_DEPTH + 1),
    localparam int QCNT_W = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DATA_W-1:0] wd_data,
    input  logic              burst_push,
    input  logic [BL_W-1:0]   burst_beats,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    output logic [FCNT_W-1:0] fifo_count
);
    logic              d_empty, d_full, q_empty, q_full;
    logic [BL_W-1:0]   head_len;
    logic [BL_W-1:0]   beat_cnt;
    logic [QCNT_W-1:0] q_count;
    logic              w_fire;

    assign wd_ready = !d_full;
    assign wvalid   = !d_empty && !q_empty;
    assign w_fire   = wvalid && wready;
    assign wlast    = (beat_cnt == head_len - 1'b1);

    wbm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_data_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wd_valid),
        .din   (wd_data),
        .pop   (w_fire),
        .dout  (wdata),
        .empty (d_empty),
        .full  (d_full),
        .count (fifo_count)
    );

    wbm_fifo #(.W(BL_W), .DEPTH(MAX_OUT)) u_len_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (burst_push),
        .din   (burst_beats),
        .pop   (w_fire && wlast),
        .dout  (head_len),
        .empty (q_empty),
        .full  (q_full),
        .count (q_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (w_fire) begin
            beat_cnt <= wlast ? '0 : beat_cnt + 1'b1;
        end
    end

    logic unused_q;
    assign unused_q = q_full ^ (^q_count);
endmodule

// File: rtl/axi_wr_burst_master.sv
module axi_wr_burst_master #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 12,
    parameter int MAX_BURST  = 16,
    parameter int MAX_OUT    = 16,
    parameter int FIFO_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_aw,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DATA_W-1:0] wd_data,
    output logic              ack_valid,
    output logic              ack_err,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    input  logic [1:0]        bresp
);
    import wbm_pkg::*;

    localparam int BYTES  = DATA_W / 8;
    localparam int OFF_W  = (BYTES > 1) ? $clog2(BYTES) : 0;
    localparam int BL_W   = $clog2(MAX_BURST + 1);
    localparam int OUT_W  = $clog2(MAX_OUT + 1);
    localparam int PEND_W = $clog2(MAX_OUT * MAX_BURST + 1);
    localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

    wbm_state_e        state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem_len;
    logic [OUT_W-1:0]  outst_cnt;
    logic [PEND_W-1:0] pend_beats;
    logic              err_flag;
    logic [BL_W-1:0]   frag_beats;
    logic [FCNT_W-1:0] fifo_count;
    logic              data_ready_ok, cap_ok;
    logic              aw_fire, w_fire, b_fire, req_fire, last_frag;

    wbm_frag #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .BYTES(BYTES)) u_frag (
        .page_off  (cur_addr[11:0]),
        .remaining (rem_len),
        .beats     (frag_beats)
    );

    wbm_wlane #(
        .DATA_W(DATA_W), .MAX_BURST(MAX_BURST),
        .MAX_OUT(MAX_OUT), .FIFO_DEPTH(FIFO_DEPTH)
    ) u_wlane (
        .clk         (clk),
        .rst_n       (rst_n),
        .wd_valid    (wd_valid),
        .wd_ready    (wd_ready),
        .wd_data     (wd_data),
        .burst_push  (aw_fire),
        .burst_beats (frag_beats),
        .wvalid      (wvalid),
        .wready      (wready),
        .wdata       (wdata),
        .wlast       (wlast),
        .fifo_count  (fifo_count)
    );

    assign cap_ok        = (outst_cnt < OUT_W'(MAX_OUT));
    assign data_ready_ok = !hold_aw ||
                           (32'(fifo_count) >= 32'(pend_beats) + 32'(frag_beats));
    assign w_fire        = wvalid && wready;
    assign b_fire        = bvalid;
    assign req_fire      = req_valid && req_ready;
    assign aw_fire       = awvalid && awready;
    assign last_frag     = (rem_len == LEN_W'(frag_beats));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid)              state_nx = ST_ISSUE;
            ST_ISSUE: if (aw_fire && last_frag)   state_nx = ST_WAIT;
            ST_WAIT:  if (outst_cnt == '0)        state_nx = ST_ACK;
            ST_ACK:                               state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        awvalid   = 1'b0;
        ack_valid = 1'b0;
        ack_err   = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: awvalid   = cap_ok && data_ready_ok;
            ST_WAIT:  ;
            ST_ACK: begin
                ack_valid = 1'b1;
                ack_err   = err_flag;
            end
            default:  ;
        endcase
    end

    assign awaddr = cur_addr;
    assign awlen  = 8'(frag_beats - 1'b1);
    assign bready = 1'b1;

    // job datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem_len  <= '0;
            err_flag <= 1'b0;
        end else begin
            if (req_fire) begin
                cur_addr <= req_addr;
                rem_len  <= req_len;
                err_flag <= 1'b0;
            end else begin
                if (aw_fire) begin
                    cur_addr <= cur_addr + (ADDR_W'(frag_beats) << OFF_W);
                    rem_len  <= rem_len - LEN_W'(frag_beats);
                end
                if (b_fire && (bresp != RESP_OKAY)) err_flag <= 1'b1;
            end
        end
    end

    // burst accounting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_cnt  <= '0;
            pend_beats <= '0;
        end else begin
            outst_cnt  <= outst_cnt + OUT_W'(aw_fire) - OUT_W'(b_fire);
            pend_beats <= pend_beats + (aw_fire ? PEND_W'(frag_beats) : '0)
                                     - PEND_W'(w_fire);
        end
    end
endmodule

// File: rtl/axi_wr_burst_master_chk.sv
module axi_wr_burst_master_chk #(
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 16,
    parameter int MAX_OUT   = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = (BYTES > 1) ? $clog2(BYTES) : 0,
    localparam int OUT_W = $clog2(MAX_OUT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awvalid,
    input logic              awready,
    input logic [11:0]       awaddr_lo,
    input logic [7:0]        awlen,
    input logic              wvalid,
    input logic              wready,
    input logic [DATA_W-1:0] wdata,
    input logic              wlast,
    input logic              ack_valid,
    input logic [OUT_W-1:0]  outst_cnt
);
    p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (32'(awlen) < 32'(MAX_BURST)));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr_lo) && $stable(awlen)));

    p_page_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (32'(awaddr_lo) + ((32'(awlen) + 1) << OFF_W) <= 32'd4096));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));

    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (32'(outst_cnt) < 32'(MAX_OUT)));

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);
endmodule

bind axi_wr_burst_master axi_wr_burst_master_chk #(
    .DATA_W(DATA_W), .MAX_BURST(MAX_BURST), .MAX_OUT(MAX_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .awvalid   (awvalid),
    .awready   (awready),
    .awaddr_lo (awaddr[11:0]),
    .awlen     (awlen),
    .wvalid    (wvalid),
    .wready    (wready),
    .wdata     (wdata),
    .wlast     (wlast),
    .ack_valid (ack_valid),
    .outst_cnt (outst_cnt)
);

// File: tb/axi_wr_burst_master_bench.sv
module axi_wr_burst_master_bench;
    localparam int ADDR_W = 32, DATA_W = 32, LEN_W = 8;
    localparam int MAXB = 4, MAXO = 2, FDEP = 8;

    logic clk = 1'b0, rst_n = 1'b0, hold_aw = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic wd_valid = 1'b0, wd_ready;
    logic [DATA_W-1:0] wd_data = '0;
    logic ack_valid, ack_err;
    logic awvalid, awready = 1'b0;
    logic [ADDR_W-1:0] awaddr;
    logic [7:0] awlen;
    logic wvalid, wready = 1'b0, wlast;
    logic [DATA_W-1:0] wdata;
    logic bvalid = 1'b0, bready;
    logic [1:0] bresp = 2'b00;

    always #10 clk = ~clk;

    axi_wr_burst_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .MAX_BURST(MAXB), .MAX_OUT(MAXO), .FIFO_DEPTH(FDEP)
    ) u_axi_wr_burst_master (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    int job_id = 0, job_len = 0;
    logic [31:0] job_addr = '0;
    bit job_on = 0, req_taken = 0, data_hold = 0, aw_hold = 0, b_hold = 0;
    bit inject = 0, err_sent = 0, ack_err_seen = 0;
    int data_sent = 0, aw_idx = 0, w_idx = 0, b_cnt = 0, b_owed = 0, ack_cnt = 0;
    int nfrag = 0;
    logic [31:0] e_addr [64];
    int e_len [64];
    int e_cum [64];
    int o_len [64];
    bit e_last [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] pat(input int j, input int i);
        return (32'(j) * 32'h9E3779B1) + (32'(i) * 32'h01000193) + 32'h5A5A0000;
    endfunction

    // expected fragmentation (R2, R3)
    task automatic build_plan(input logic [31:0] a, input int len);
        int rem = len, cum = 0, room, b;
        nfrag = 0;
        while (rem > 0) begin
            room = (4096 - int'(a[11:0])) / 4;
            b = rem;
            if (b > MAXB) b = MAXB;
            if (b > room) b = room;
            e_addr[nfrag] = a;
            e_len[nfrag]  = b;
            for (int k = 0; k < b; k++) e_last[cum + k] = (k == b - 1);
            cum += b;
            e_cum[nfrag] = cum;
            a += 32'(b * 4);
            rem -= b;
            nfrag++;
        end
    endtask

    task automatic start_job(input logic [31:0] a, input int len, input bit mode,
                             input bit inj, input bit dh, input bit ah, input bit bh);
        @(negedge clk);
        job_id++;
        job_addr = a; job_len = len; hold_aw = mode; inject = inj;
        data_hold = dh; aw_hold = ah; b_hold = bh;
        req_taken = 0; err_sent = 0; data_sent = 0; aw_idx = 0; w_idx = 0;
        b_cnt = 0; b_owed = 0; ack_cnt = 0; ack_err_seen = 0;
        build_plan(a, len);
        job_on = 1;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        int t = 0;
        data_hold = 0; aw_hold = 0; b_hold = 0;
        while (ack_cnt == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (ack_cnt == 0) begin
            chk(0, "R9 timeout", 0, 1);
            report();
        end
        @(negedge clk); #9;
        chk(req_ready == 1'b1, "R12", int'(req_ready), 1);
        wait_cycles(3);
        chk(ack_cnt == 1, "R9", ack_cnt, 1);
        chk(aw_idx == nfrag, "R2", aw_idx, nfrag);
        chk(w_idx == job_len, "R4", w_idx, job_len);
        chk(ack_err_seen == inject, "R10", int'(ack_err_seen), int'(inject));
        job_on = 0;
    endtask

    // cycle engine: drive at negedge+1, observe at negedge+9
    initial begin
        forever begin
            @(negedge clk);
            #1;
            cyc++;
            if (cyc > 150000) begin
                chk(0, "watchdog", cyc, 150000);
                report();
            end
            req_valid = job_on && !req_taken;
            req_addr  = job_addr;
            req_len   = LEN_W'(job_len);
            wd_valid  = job_on && (data_sent < job_len) && !data_hold && ($urandom % 4 != 0);
            wd_data   = pat(job_id, data_sent);
            awready   = !aw_hold && ($urandom % 4 != 0);
            wready    = ($urandom % 4 != 0);
            bvalid    = (b_owed > 0) && !b_hold && ($urandom % 3 == 0);
            bresp     = (inject && !err_sent) ? 2'b10 : 2'b00;
            #8;
            if (rst_n && job_on) begin
                if (req_valid && req_ready) req_taken = 1;
                if (awvalid && awready) begin
                    if (aw_idx < nfrag) begin
                        chk(awaddr == e_addr[aw_idx], "R2 addr", int'(awaddr), int'(e_addr[aw_idx]));
                        chk(int'(awlen) == e_len[aw_idx] - 1, "R2 len", int'(awlen), e_len[aw_idx] - 1);
                        if (hold_aw)
                            chk(data_sent >= e_cum[aw_idx], "R6", data_sent, e_cum[aw_idx]);
                    end else chk(0, "R2 extra burst", aw_idx, nfrag);
                    chk(int'(awaddr[11:0]) + (int'(awlen) + 1) * 4 <= 4096, "R3",
                        int'(awaddr[11:0]), int'(awlen));
                    chk(aw_idx - b_cnt < MAXO, "R8", aw_idx - b_cnt, MAXO);
                    o_len[aw_idx % 64] = int'(awlen) + 1;
                    aw_idx++;
                end
                if (wd_valid && wd_ready) data_sent++;
                if (wvalid && wready) begin
                    chk(wdata == pat(job_id, w_idx), "R4", int'(wdata), int'(pat(job_id, w_idx)));
                    chk(wlast == e_last[w_idx % 256], "R5", int'(wlast), int'(e_last[w_idx % 256]));
                    if (wlast) b_owed++;
                    w_idx++;
                end
                if (bvalid) begin
                    if (bready) begin
                        b_owed--; b_cnt++; err_sent = 1;
                    end else chk(0, "R9 bready", 0, 1);
                end
                if (ack_valid) begin
                    ack_cnt++;
                    ack_err_seen = ack_err;
                    chk(b_cnt == nfrag, "R9 order", b_cnt, nfrag);
                end
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_cycles(5);
        #9;
        rst_n = 1'b1;
        @(negedge clk); #9;
        chk(awvalid == 0, "R1", int'(awvalid), 0);
        chk(wvalid == 0, "R1", int'(wvalid), 0);
        chk(ack_valid == 0, "R1", int'(ack_valid), 0);
        chk(req_ready == 1, "R1", int'(req_ready), 1);

        // R7: immediate mode issues address with no data delivered
        start_job(32'h100, 4, 0, 0, 1, 0, 0);
        wait_cycles(20);
        chk(aw_idx == 1, "R7", aw_idx, 1);
        chk(data_sent == 0, "R7", data_sent, 0);
        wait_done();

        // R6: hold mode keeps the address back without data
        start_job(32'h200, 4, 1, 0, 1, 0, 0);
        wait_cycles(20);
        chk(aw_idx == 0, "R6", aw_idx, 0);
        wait_done();

        // R11: FIFO fills while the address channel is stalled
        start_job(32'h300, 12, 1, 0, 0, 1, 0);
        wait_cycles(40);
        chk(data_sent == FDEP, "R11", data_sent, FDEP);
        chk(wd_ready == 0, "R11", int'(wd_ready), 0);
        wait_done();

        // R8 / R12: responses withheld
        start_job(32'h0, 12, 0, 0, 0, 0, 1);
        wait_cycles(60);
        chk(aw_idx == MAXO, "R8", aw_idx, MAXO);
        chk(req_ready == 0, "R12", int'(req_ready), 1'b0);
        wait_done();

        // R3: job starting three words before a page end
        start_job(32'h0000_0FF4, 10, 1, 0, 0, 0, 0);
        wait_done();
        chk(o_len[0] == 3, "R3", o_len[0], 3);
        chk(o_len[1] == 4, "R3", o_len[1], 4);

        // R10: error response merged into acknowledgement
        start_job(32'h1FF8, 9, 0, 1, 0, 0, 0);
        wait_done();

        // single word job
        start_job(32'h400, 1, 1, 0, 0, 0, 0);
        wait_done();

        // constrained random jobs
        for (int j = 0; j < 40; j++) begin
            logic [31:0] a;
            if ($urandom % 2 == 0) a = 32'(($urandom % 8 + 1) * 4096) - 32'(4 * ($urandom % 10));
            else                   a = 32'(4 * ($urandom % 4000));
            start_job(a, 1 + int'($urandom % 40), 1'($urandom % 2), ($urandom % 4 == 0), 0, 0, 0);
            wait_done();
        end
        report();
    end
endmodule